// File: doc/BRIEF.md
# Byte-Compare Terminated String Loader

This block copies a run of bytes from byte-addressed memory into a bank of 32-bit registers. It fetches one byte at a time. Each byte goes into one 8-bit lane of the current register, and the other lanes of that register are left alone. The run stops after a programmed number of bytes, or sooner when a fetched byte equals a compare byte. When it finishes, the block reports how many bytes it stepped past before stopping.

A command is a one-cycle `start_i` pulse that carries the following values:
- a base address;
- an address-mode select;
- the first destination register;
- the numbers of two protected registers (a base register and an index register);
- a 7-bit byte count;
- an 8-bit compare value.

The block sends one read request per byte. Each returned byte appears as a single write on a byte-lane register write port. A neighbouring register file merges that write. At the end the block raises a one-cycle completion pulse together with the result count.

Top module: `byte_scan_loader`

## Requirements
- R1: Bytes fill each register from its most significant lane down. `wr_lane_o` value 3 selects bits 31:24, 2 selects bits 23:16, 1 selects bits 15:8 and 0 selects bits 7:0. The first byte goes to lane 3 of `first_reg_i`. The byte after a lane-0 byte goes to lane 3 of the next register number.
- R2: Advancing from register 31 continues at register 0. Register numbers wrap modulo 32.
- R3: Every register write carries exactly one byte: the fetched byte, unchanged, tagged with its register and lane. The other three bytes of that register stay as they were.
- R4: No byte is ever written to the register named by `index_reg_i`. No byte is written to the register named by `base_reg_i` when that number is nonzero. Register 0 named as base is written normally. A skipped byte is still fetched, compared and counted, and the lane position still advances past it.
- R5: When a fetched byte equals `cmp_byte_i`, the run stops after that byte. The matching byte is still written, unless R4 skips it. The result count is the zero-based position of the matching byte.
- R6: With no match, the result count equals the byte count. A byte count of zero issues no memory request and completes in the cycle after the start.
- R7: The first read uses the base address unchanged. Each following read uses the previous address plus one. When `mode32_i` was 1 at the start, bits above 31 of each incremented address are cleared.
- R8: `done_o` is high for exactly one cycle per accepted command, and `count_o` is valid in that cycle. A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command pulse, accepted only when idle |
| base_addr_i | input | 64 | Address of the first byte |
| mode32_i | input | 1 | 1 = addresses wrap within 32 bits |
| first_reg_i | input | 5 | First destination register |
| base_reg_i | input | 5 | Protected base register (not protected when 0) |
| index_reg_i | input | 5 | Protected index register |
| byte_cnt_i | input | 7 | Maximum number of bytes to load |
| cmp_byte_i | input | 8 | Terminating byte value |
| mem_req_o | output | 1 | Byte read request, held until acknowledged |
| mem_addr_o | output | 64 | Byte read address |
| mem_ack_i | input | 1 | Read acknowledge; data valid with it |
| mem_data_i | input | 8 | Returned byte |
| wr_en_o | output | 1 | Register byte write strobe |
| wr_reg_o | output | 5 | Register number being written |
| wr_lane_o | output | 2 | Byte lane being written (3 = bits 31:24) |
| wr_data_o | output | 8 | Byte being written |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 7 | Result count, valid with `done_o` |

## Verification
The embedded properties assume the following about the inputs:
- `mem_ack_i` is raised only while `mem_req_o` is high.
- `mem_data_i` is valid in the same cycle as the acknowledge.
- The command fields are meaningful only in the cycle `start_i` is high.

The bench's memory responder follows these rules. It raises a single-cycle acknowledge only in answer to a pending request, and it computes the returned byte from the address being requested. The bench changes command fields only together with a start pulse. The one exception is a deliberate second start during a busy run, which R8 requires to be ignored.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } bsl_state_e;
endpackage

// File: rtl/bsl_addr_step.sv
module bsl_addr_step #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              m32_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] next_addr;
  logic              m32_q;

  assign inc = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};

  generate
    if (ADDR_W > 32) begin : g_wide
      always_comb begin
        if (m32_q) next_addr = {{(ADDR_W-32){1'b0}}, inc[31:0]};
        else       next_addr = inc;
      end
    end else begin : g_narrow
      always_comb next_addr = inc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      m32_q  <= 1'b0;
    end else if (load_i) begin
      addr_q <= base_i;
      m32_q  <= m32_i;
    end else if (step_i) begin
      addr_q <= next_addr;
    end
  end

  assign addr_o = addr_q;

  generate
    if (ADDR_W > 32) begin : g_chk
      assert_high_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (step_i && m32_q) |=> (addr_q[ADDR_W-1:32] == '0));
    end
  endgenerate
endmodule

// File: rtl/bsl_lane_walk.sv
module bsl_lane_walk #(
  parameter int NREGS = 32,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [$clog2(NREGS)-1:0]   first_i,
  input  logic                       step_i,
  output logic [$clog2(NREGS)-1:0]   reg_o,
  output logic [$clog2(LANES)-1:0]   lane_o
);
  localparam int REG_W  = $clog2(NREGS);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);
  localparam logic [REG_W-1:0]  REG_TOP  = REG_W'(NREGS - 1);

  logic [REG_W-1:0]  reg_q;
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= '0;
      lane_q <= LANE_TOP;
    end else if (load_i) begin
      reg_q  <= first_i;
      lane_q <= LANE_TOP;
    end else if (step_i) begin
      if (lane_q == '0) begin
        lane_q <= LANE_TOP;
        reg_q  <= (reg_q == REG_TOP) ? '0 : reg_q + 1'b1;
      end else begin
        lane_q <= lane_q - 1'b1;
      end
    end
  end

  assign reg_o  = reg_q;
  assign lane_o = lane_q;

  assert_lane_restart_R1: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && lane_q == '0) |=> (lane_q == LANE_TOP));
  assert_reg_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && lane_q != '0) |=> (reg_q == $past(reg_q)));
  assert_reg_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && lane_q == '0 && reg_q == REG_TOP) |=> (reg_q == '0));
endmodule

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [BYTE_W-1:0] cmp_i,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              load_o,
  output logic              take_o,
  output logic              step_o,
  output logic              req_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o
);
  bsl_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  idx_q;
  logic [BYTE_W-1:0] cmp_q;
  logic              hit;
  logic              last;

  always_comb begin
    load_o = (state_q == ST_IDLE) && start_i;
    take_o = (state_q == ST_FETCH) && ack_i;
    hit    = (data_i == cmp_q);
    last   = (idx_q == cnt_q - 1'b1);
    step_o = take_o && !hit && !last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      cmp_q   <= '0;
      req_o   <= 1'b0;
      done_o  <= 1'b0;
      count_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        cnt_q <= cnt_i;
        cmp_q <= cmp_i;
        idx_q <= '0;
        if (cnt_i == '0) begin
          done_o  <= 1'b1;
          count_o <= '0;
        end else begin
          state_q <= ST_FETCH;
          req_o   <= 1'b1;
        end
      end else if (take_o) begin
        if (hit || last) begin
          state_q <= ST_IDLE;
          req_o   <= 1'b0;
          done_o  <= 1'b1;
          count_o <= hit ? idx_q : cnt_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && cnt_i == '0) |=> (done_o && count_o == '0 && !req_o));
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (count_o <= cnt_q));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH && !take_o) |=> ($stable(cnt_q) && $stable(cmp_q)));
endmodule

// File: rtl/byte_scan_loader.sv
module byte_scan_loader
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int NREGS  = 32,
  parameter int CNT_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          base_addr_i,
  input  logic                       mode32_i,
  input  logic [$clog2(NREGS)-1:0]   first_reg_i,
  input  logic [$clog2(NREGS)-1:0]   base_reg_i,
  input  logic [$clog2(NREGS)-1:0]   index_reg_i,
  input  logic [CNT_W-1:0]           byte_cnt_i,
  input  logic [7:0]                 cmp_byte_i,
  output logic                       mem_req_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  input  logic                       mem_ack_i,
  input  logic [7:0]                 mem_data_i,
  output logic                       wr_en_o,
  output logic [$clog2(NREGS)-1:0]   wr_reg_o,
  output logic [$clog2(DATA_W/8)-1:0] wr_lane_o,
  output logic [7:0]                 wr_data_o,
  output logic                       done_o,
  output logic [CNT_W-1:0]           count_o
);
  localparam int REG_W  = $clog2(NREGS);
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  logic              load;
  logic              take;
  logic              step;
  logic [REG_W-1:0]  cur_reg;
  logic [LANE_W-1:0] cur_lane;
  logic [REG_W-1:0]  base_reg_q;
  logic [REG_W-1:0]  index_reg_q;
  logic              skip;

  bsl_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cnt_i   (byte_cnt_i),
    .cmp_i   (cmp_byte_i),
    .ack_i   (mem_ack_i),
    .data_i  (mem_data_i),
    .load_o  (load),
    .take_o  (take),
    .step_o  (step),
    .req_o   (mem_req_o),
    .done_o  (done_o),
    .count_o (count_o)
  );

  bsl_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .base_i (base_addr_i),
    .m32_i  (mode32_i),
    .step_i (step),
    .addr_o (mem_addr_o)
  );

  bsl_lane_walk #(.NREGS(NREGS), .LANES(LANES)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .first_i (first_reg_i),
    .step_i  (step),
    .reg_o   (cur_reg),
    .lane_o  (cur_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_reg_q  <= '0;
      index_reg_q <= '0;
    end else if (load) begin
      base_reg_q  <= base_reg_i;
      index_reg_q <= index_reg_i;
    end
  end

  assign skip = (cur_reg == index_reg_q) ||
                ((base_reg_q != '0) && (cur_reg == base_reg_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_reg_o  <= '0;
      wr_lane_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= take && !skip;
      if (take) begin
        wr_reg_o  <= cur_reg;
        wr_lane_o <= cur_lane;
        wr_data_o <= mem_data_i;
      end
    end
  end

  assert_no_index_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_reg_o != index_reg_q));
  assert_no_base_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && base_reg_q != '0) |-> (wr_reg_o != base_reg_q));
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> (mem_addr_o[31:0] == $past(mem_addr_o[31:0]) + 32'd1));
  assert_write_data_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !skip) |=> (wr_en_o && wr_data_o == $past(mem_data_i)));
  assert_write_before_done_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_req_o);
endmodule

// File: tb/byte_scan_loader_tb.sv
module byte_scan_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] base_addr_i = '0;
  logic        mode32_i = 1'b0;
  logic [4:0]  first_reg_i = '0;
  logic [4:0]  base_reg_i = '0;
  logic [4:0]  index_reg_i = '0;
  logic [6:0]  byte_cnt_i = '0;
  logic [7:0]  cmp_byte_i = '0;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic        wr_en_o;
  logic [4:0]  wr_reg_o;
  logic [1:0]  wr_lane_o;
  logic [7:0]  wr_data_o;
  logic        done_o;
  logic [6:0]  count_o;

  always #2 clk = ~clk;

  byte_scan_loader u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .base_addr_i(base_addr_i),
    .mode32_i(mode32_i), .first_reg_i(first_reg_i), .base_reg_i(base_reg_i),
    .index_reg_i(index_reg_i), .byte_cnt_i(byte_cnt_i), .cmp_byte_i(cmp_byte_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_data_i(mem_data_i), .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o),
    .wr_lane_o(wr_lane_o), .wr_data_o(wr_data_o), .done_o(done_o), .count_o(count_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int obs_n = 0;
  int done_cnt = 0;
  int pulse_err = 0;
  int req_seen = 0;
  logic [6:0]  last_count = '0;
  logic        prev_done = 1'b0;
  logic [63:0] obs_addr [0:127];
  logic [63:0] exp_addr [0:127];
  logic [31:0] rf [0:31];
  logic [31:0] exp_rf [0:31];

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic logic [63:0] next_addr(input logic [63:0] a, input logic m32);
    logic [63:0] n;
    n = a + 64'd1;
    if (m32) n = {32'd0, n[31:0]};
    return n;
  endfunction

  // memory responder and monitor of the register write port
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (done_o) begin
      done_cnt = done_cnt + 1;
      last_count = count_o;
      if (prev_done) pulse_err = pulse_err + 1;
    end
    prev_done = done_o;
    if (wr_en_o) rf[wr_reg_o][wr_lane_o*8 +: 8] = wr_data_o;
    if (mem_req_o) req_seen = req_seen + 1;
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i = 1'b1;
      mem_data_i = mem_byte(mem_addr_o);
      if (obs_n < 128) obs_addr[obs_n] = mem_addr_o;
      obs_n = obs_n + 1;
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] absent_cmp(input logic [63:0] base, input logic m32,
                                            input int cnt);
    for (int c = 0; c < 256; c++) begin
      logic [63:0] a;
      bit found;
      a = base;
      found = 1'b0;
      for (int i = 0; i < cnt; i++) begin
        if (mem_byte(a) == 8'(c)) found = 1'b1;
        a = next_addr(a, m32);
      end
      if (!found) return 8'(c);
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] cmp_at(input logic [63:0] base, input logic m32, input int k);
    logic [63:0] a;
    a = base;
    for (int i = 0; i < k; i++) a = next_addr(a, m32);
    return mem_byte(a);
  endfunction

  task automatic run_case(input string req, input logic [63:0] base, input logic m32,
                          input logic [4:0] first, input logic [4:0] breg,
                          input logic [4:0] ireg, input int cnt,
                          input logic [7:0] cmp, input bit poke);
    logic [63:0] a;
    logic [4:0]  r;
    logic [1:0]  ln;
    int          exp_cnt;
    int          exp_n;
    int          t;
    int          bad;
    logic [7:0]  b;
    for (int i = 0; i < 32; i++) begin
      rf[i] = {8'(i), 8'hC3, 8'(i ^ 5), 8'h96};
      exp_rf[i] = rf[i];
    end
    a = base; r = first; ln = 2'd3; exp_cnt = cnt; exp_n = 0;
    for (int i = 0; i < cnt; i++) begin
      b = mem_byte(a);
      exp_addr[exp_n] = a;
      exp_n++;
      if (r != ireg && !(breg != 5'd0 && r == breg)) exp_rf[r][ln*8 +: 8] = b;
      if (b == cmp) begin
        exp_cnt = i;
        break;
      end
      if (ln == 2'd0) begin
        ln = 2'd3;
        r = r + 5'd1;
      end else begin
        ln = ln - 2'd1;
      end
      a = next_addr(a, m32);
    end
    @(negedge clk);
    obs_n = 0; done_cnt = 0; pulse_err = 0; req_seen = 0;
    base_addr_i = base; mode32_i = m32; first_reg_i = first; base_reg_i = breg;
    index_reg_i = ireg; byte_cnt_i = 7'(cnt); cmp_byte_i = cmp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      base_addr_i = 64'h40; first_reg_i = 5'd9; byte_cnt_i = 7'd2;
      cmp_byte_i = mem_byte(64'h40); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1 && pulse_err == 0, "R8", "single done pulse", 64'(done_cnt), 64'd1);
    chk(last_count == 7'(exp_cnt), req, "result count", 64'(last_count), 64'(exp_cnt));
    chk(obs_n == exp_n, "R7", "read count", 64'(obs_n), 64'(exp_n));
    bad = -1;
    for (int i = 0; i < exp_n && i < obs_n; i++)
      if (bad < 0 && obs_addr[i] != exp_addr[i]) bad = i;
    if (bad >= 0) chk(1'b0, "R7", "read address", obs_addr[bad], exp_addr[bad]);
    else          chk(1'b1, "R7", "read address", 64'd0, 64'd0);
    bad = -1;
    for (int i = 0; i < 32; i++)
      if (bad < 0 && rf[i] != exp_rf[i]) bad = i;
    if (bad >= 0) chk(1'b0, req, $sformatf("register %0d", bad), 64'(rf[bad]), 64'(exp_rf[bad]));
    else          chk(1'b1, req, "register file", 64'd0, 64'd0);
    if (cnt == 0) chk(req_seen == 0, "R6", "no request on zero count", 64'(req_seen), 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!done_o && !mem_req_o && !wr_en_o && count_o == '0, "R8", "reset outputs",
        {60'd0, done_o, mem_req_o, wr_en_o, 1'b0}, 64'd0);
  endtask

  task automatic t_zero;
    run_case("R6", 64'h100, 1'b0, 5'd3, 5'd0, 5'd1, 0, 8'h00, 1'b0);
  endtask

  task automatic t_no_match;
    run_case("R1 R3", 64'h200, 1'b0, 5'd4, 5'd2, 5'd1, 10,
             absent_cmp(64'h200, 1'b0, 10), 1'b0);
  endtask

  task automatic t_match_mid;
    run_case("R5", 64'h300, 1'b0, 5'd10, 5'd0, 5'd1, 16,
             cmp_at(64'h300, 1'b0, 5), 1'b0);
  endtask

  task automatic t_match_first;
    run_case("R5", 64'h355, 1'b0, 5'd12, 5'd0, 5'd1, 16,
             cmp_at(64'h355, 1'b0, 0), 1'b0);
  endtask

  task automatic t_reg_wrap;
    run_case("R2", 64'h480, 1'b0, 5'd30, 5'd0, 5'd5, 12,
             absent_cmp(64'h480, 1'b0, 12), 1'b0);
  endtask

  task automatic t_skip_regs;
    run_case("R4", 64'h520, 1'b0, 5'd6, 5'd7, 5'd8, 16,
             absent_cmp(64'h520, 1'b0, 16), 1'b0);
  endtask

  task automatic t_base_zero;
    run_case("R4", 64'h610, 1'b0, 5'd0, 5'd0, 5'd2, 6,
             absent_cmp(64'h610, 1'b0, 6), 1'b0);
  endtask

  task automatic t_match_skipped;
    run_case("R4 R5", 64'h700, 1'b0, 5'd6, 5'd7, 5'd8, 16,
             cmp_at(64'h700, 1'b0, 5), 1'b0);
  endtask

  task automatic t_addr32;
    run_case("R7", 64'h1_FFFF_FFFE, 1'b1, 5'd1, 5'd0, 5'd0, 5,
             absent_cmp(64'h1_FFFF_FFFE, 1'b1, 5), 1'b0);
  endtask

  task automatic t_addr64;
    run_case("R7", 64'h1_FFFF_FFFE, 1'b0, 5'd1, 5'd0, 5'd0, 5,
             absent_cmp(64'h1_FFFF_FFFE, 1'b0, 5), 1'b0);
  endtask

  task automatic t_max_count;
    run_case("R6", 64'h800, 1'b0, 5'd0, 5'd0, 5'd31, 127,
             absent_cmp(64'h800, 1'b0, 127), 1'b0);
  endtask

  task automatic t_busy_start;
    run_case("R8", 64'h900, 1'b0, 5'd14, 5'd0, 5'd1, 20,
             absent_cmp(64'h900, 1'b0, 20), 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero();
    t_no_match();
    t_match_mid();
    t_match_first();
    t_reg_wrap();
    t_skip_regs();
    t_base_zero();
    t_match_skipped();
    t_addr32();
    t_addr64();
    t_max_count();
    t_busy_start();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule